// File: doc/BRIEF.md
# Infrared Pulse-Width Capture Timer

This block is an up-counter with a programmable start value. It records the moment of edges on one input pin so that software can measure the widths of infrared remote-control pulses. A running count is copied into a capture register when a selected edge arrives. In the polling mode the capture register instead shows the live count. In the telegram-start mode a two-event filter decides whether the first pulse is real before it raises an interrupt.

In the telegram-start mode the first edge only rearms the counter. The second edge captures the elapsed time. An interrupt pulse is raised only if that time is above a programmable minimum and the counter has not wrapped. Short or overlong pulses are dropped silently, and the counter rearms itself. Software reads the capture register as an upper and a lower half, together with the overflow and first-event flags.

Top module: `ir_pulse_timer`

## Requirements
- R1: A rising edge of `run` loads the counter with `reload_val` and clears `overflow` and `first`. It also returns the telegram filter to waiting for a first edge.
- R2: While `run` is high the counter advances by one each clock. While `run` is low the counter holds its value, pin edges are ignored and `irq` stays 0.
- R3: When the counter steps past the all-ones value it loads `reload_val` and sets `overflow`. The flag then stays set until a clearing rule (R1, R7 or R9) applies.
- R4: A pin event is a rising edge while `rise_en` is 1 or a falling edge while `fall_en` is 1. It is seen through a two-flop synchronizer. With `poll_en` = 0, the capture register is written on the third clock edge after the pin changes, with the count held after the second edge. `{cap_hi, cap_lo}` forms the capture value, with `cap_hi` as the upper half.
- R5: In normal capture (`poll_en` = 0, `start_en` = 0), an event reloads the counter only when `reload_en` is 1. Otherwise counting goes on from the current value. A capture never changes `overflow`, and no interrupt is raised.
- R6: With `poll_en` = 1, `{cap_hi, cap_lo}` shows the live counter, and pin events and `start_en` have no effect. No interrupt is raised.
- R7: With `start_en` = 1 and `poll_en` = 0, the first event captures the count and sets `first`. It clears `overflow` and loads `reload_val` whatever `reload_enable` says, and it raises no interrupt.
- R8: The second event captures the count and clears `first`. If the captured value is strictly greater than `min_cap` and `overflow` is 0, `irq` is 1 for exactly one cycle. After this the block acts as normal capture until it is rearmed by a `run` rising edge or by `start_en` going low.
- R9: A second event whose count is at or below `min_cap`, or that arrives with `overflow` set, is a spike. It raises no interrupt, clears `overflow` and loads `reload_val`.
- R10: After a spike, `first` stays 1 when only one of `rise_en` and `fall_en` is set. It returns to 0 when both are set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run | input | 1 | Counter enable; a rising edge starts a measurement |
| poll_en | input | 1 | Polling mode select |
| start_en | input | 1 | Telegram-start filter enable |
| reload_en | input | 1 | Reload on each capture in normal mode |
| rise_en | input | 1 | Rising pin edges count as events |
| fall_en | input | 1 | Falling pin edges count as events |
| reload_val | input | WIDTH | Counter start and wrap value |
| min_cap | input | WIDTH | Threshold a valid second capture must exceed |
| pin | input | 1 | Asynchronous pin being timed |
| cap_hi | output | WIDTH-WIDTH/2 | Upper half of the capture value |
| cap_lo | output | WIDTH/2 | Lower half of the capture value |
| overflow | output | 1 | Sticky counter-wrap flag |
| first | output | 1 | First telegram edge seen, waiting for the second |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
The bench builds the block with WIDTH = 8. At that width the wrap from all-ones happens within a few hundred cycles. This makes the sticky overflow flag, its survival across a normal capture, and a second telegram edge that arrives after a wrap all cheap to reach. The 8-bit width also leaves room for threshold boundary cases: a capture equal to `min_cap` and one just above it.

// File: rtl/ir_pulse_timer.sv
module ir_pulse_timer #(
  parameter int WIDTH = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     run,
  input  logic                     poll_en,
  input  logic                     start_en,
  input  logic                     reload_en,
  input  logic                     rise_en,
  input  logic                     fall_en,
  input  logic [WIDTH-1:0]         reload_val,
  input  logic [WIDTH-1:0]         min_cap,
  input  logic                     pin,
  output logic [WIDTH-WIDTH/2-1:0] cap_hi,
  output logic [WIDTH/2-1:0]       cap_lo,
  output logic                     overflow,
  output logic                     first,
  output logic                     irq
);
  localparam int HALF = WIDTH / 2;

  typedef enum logic [1:0] {ARM_FIRST, ARM_SECOND, ARM_DONE} arm_t;

  logic [1:0]       sync_q;
  logic             pin_d;
  logic             run_q;
  logic [WIDTH-1:0] cnt;
  logic [WIDTH-1:0] cap_q;
  logic             ov_q;
  logic             irq_q;
  arm_t             arm;

  wire active    = run & run_q;
  wire run_go    = run & ~run_q;
  wire wrap      = (cnt == {WIDTH{1'b1}});
  wire edge_hit  = (rise_en & sync_q[1] & ~pin_d) | (fall_en & ~sync_q[1] & pin_d);
  wire evt       = active & ~poll_en & edge_hit;
  wire first_evt = evt & start_en & (arm == ARM_FIRST);
  wire second_evt = evt & start_en & (arm == ARM_SECOND);
  wire accept    = second_evt & (cnt > min_cap) & ~ov_q;
  wire reject    = second_evt & ~accept;
  wire do_reload = first_evt | reject | (evt & reload_en);
  wire [WIDTH-1:0] cnt_step = wrap ? reload_val : cnt + 1'b1;
  wire [WIDTH-1:0] cap_view = poll_en ? cnt : cap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      pin_d  <= 1'b0;
    end else begin
      sync_q <= {sync_q[0], pin};
      pin_d  <= sync_q[1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      cnt   <= '0;
      cap_q <= '0;
      ov_q  <= 1'b0;
      irq_q <= 1'b0;
      arm   <= ARM_FIRST;
    end else begin
      run_q <= run;
      irq_q <= accept;
      if (run_go) begin
        cnt  <= reload_val;
        ov_q <= 1'b0;
        arm  <= ARM_FIRST;
      end else if (active) begin
        cnt <= do_reload ? reload_val : cnt_step;
        if (first_evt | reject) ov_q <= 1'b0;
        else if (wrap)          ov_q <= 1'b1;
        if (evt) cap_q <= cnt;
        if (!start_en)      arm <= ARM_FIRST;
        else if (first_evt) arm <= ARM_SECOND;
        else if (accept)    arm <= ARM_DONE;
        else if (reject)    arm <= (rise_en & fall_en) ? ARM_FIRST : ARM_SECOND;
      end
    end
  end

  assign cap_hi   = cap_view[WIDTH-1:HALF];
  assign cap_lo   = cap_view[HALF-1:0];
  assign overflow = ov_q;
  assign first    = (arm == ARM_SECOND);
  assign irq      = irq_q;

  assert_run_go_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !run_q) |=> (cnt == $past(reload_val) && !overflow && !first));

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> ($stable(cnt) && !irq));

  assert_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (active && wrap && !evt) |=> (overflow && cnt == $past(reload_val)));

  assert_irq_mode_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(start_en && !poll_en && run));

  assert_irq_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  assert_irq_first_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (!first && $past(first)));

  assert_reject_R9: assert property (@(posedge clk) disable iff (!rst_n)
    reject |=> (!overflow && !irq && cnt == $past(reload_val)));

  assert_rearm_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (reject && rise_en && fall_en) |=> !first);
endmodule

// File: tb/ir_pulse_timer_tb.sv
module ir_pulse_timer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic run = 0, poll_en = 0, start_en = 0, reload_en = 0, rise_en = 1, fall_en = 1;
  logic [W-1:0] reload_val = '0, min_cap = '0;
  logic pin = 1'b0;
  logic [W-W/2-1:0] cap_hi;
  logic [W/2-1:0] cap_lo;
  logic overflow, first, irq;
  int checks = 0, fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ir_pulse_timer #(.WIDTH(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .run(run), .poll_en(poll_en), .start_en(start_en),
    .reload_en(reload_en), .rise_en(rise_en), .fall_en(fall_en),
    .reload_val(reload_val), .min_cap(min_cap), .pin(pin),
    .cap_hi(cap_hi), .cap_lo(cap_lo), .overflow(overflow), .first(first), .irq(irq)
  );

  // each entry: reload_en, reload, d1, d2
  localparam logic [31:0] VEC [5] = '{
    {8'd1, 8'd0,   8'd5,  8'd9},
    {8'd0, 8'd10,  8'd4,  8'd6},
    {8'd1, 8'd100, 8'd0,  8'd30},
    {8'd0, 8'd3,   8'd12, 8'd1},
    {8'd1, 8'd200, 8'd20, 8'd20}
  };

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int cap();
    return int'({cap_hi, cap_lo});
  endfunction

  task automatic start_run(int rld, bit pl, bit st, bit rl, bit re, bit fe, int mn);
    @(negedge clk);
    run = 0;
    reload_val = W'(rld); poll_en = pl; start_en = st; reload_en = rl;
    rise_en = re; fall_en = fe; min_cap = W'(mn);
    repeat (3) @(negedge clk);
    run = 1;
    @(negedge clk);
  endtask

  // captured value = count at call + d + 2
  task automatic pulse_after(int d);
    repeat (d) @(negedge clk);
    pin = ~pin;
    repeat (3) @(negedge clk);
  endtask

  task automatic rise_after(int g);
    pin = 1'b0;
    repeat (g) @(negedge clk);
    pin = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset cap", cap(), 0);
    chk("R1 reset overflow", overflow, 0);
    chk("R1 reset first", first, 0);
    chk("R1 reset irq", irq, 0);
    rst_n = 1'b1;

    foreach (VEC[i]) begin
      int rl = VEC[i][31:24], rv = VEC[i][23:16], d1 = VEC[i][15:8], d2 = VEC[i][7:0];
      int c2;
      start_run(rv, 0, 0, rl[0], 1, 1, 0);
      pulse_after(d1);
      chk("R4 normal capture 1", cap(), rv + d1 + 2);
      c2 = rl[0] ? rv + d2 + 2 : rv + d1 + 3 + d2 + 2;
      pulse_after(d2);
      chk("R5 normal capture 2", cap(), c2);
      chk("R5 overflow untouched", overflow, 0);
      chk("R5 no irq", irq, 0);
    end

    start_run(250, 1, 1, 0, 1, 1, 0);
    chk("R6 poll mirror", cap(), 250);
    repeat (5) @(negedge clk);
    chk("R6 poll mirror max", cap(), 255);
    chk("R3 no overflow before wrap", overflow, 0);
    pin = ~pin;
    @(negedge clk);
    chk("R3 wrap reload", cap(), 250);
    chk("R3 wrap sets overflow", overflow, 1);
    repeat (3) @(negedge clk);
    chk("R6 pin ignored in poll", cap(), 253);
    chk("R6 no irq in poll", irq, 0);
    chk("R6 start ignored in poll", first, 0);

    poll_en = 0; start_en = 0; reload_en = 1;
    pulse_after(0);
    chk("R4 capture after poll", cap(), 255);
    chk("R5 capture keeps overflow", overflow, 1);

    run = 0; poll_en = 1;
    repeat (4) @(negedge clk);
    chk("R2 hold while stopped", cap(), 250);
    pin = ~pin;
    repeat (4) @(negedge clk);
    chk("R2 hold after pin edge", cap(), 250);
    chk("R2 no irq while stopped", irq, 0);
    chk("R2 overflow held", overflow, 1);
    run = 1;
    @(negedge clk);
    chk("R1 run rise clears overflow", overflow, 0);
    chk("R1 run rise loads reload", cap(), 250);

    start_run(0, 0, 1, 0, 1, 1, 10);
    pulse_after(5);
    chk("R7 first capture", cap(), 7);
    chk("R7 first flag", first, 1);
    chk("R7 no irq", irq, 0);
    pulse_after(20);
    chk("R8 second capture", cap(), 22);
    chk("R8 irq", irq, 1);
    chk("R8 first cleared", first, 0);
    @(negedge clk);
    chk("R8 irq one cycle", irq, 0);
    pulse_after(3);
    chk("R8 then normal capture", cap(), 29);
    chk("R8 then no irq", irq, 0);

    start_run(0, 0, 1, 0, 1, 1, 10);
    pulse_after(5);
    pulse_after(8);
    chk("R9 equal threshold capture", cap(), 10);
    chk("R9 equal threshold no irq", irq, 0);
    chk("R10 both edges rearm", first, 0);
    pulse_after(2);
    chk("R9 reload after spike", cap(), 4);
    chk("R7 first again", first, 1);
    pulse_after(9);
    chk("R8 just above threshold", irq, 1);

    start_run(0, 0, 1, 0, 1, 0, 10);
    rise_after(5);
    chk("R7 rise-only first", first, 1);
    rise_after(2);
    chk("R9 rise-only spike capture", cap(), 4);
    chk("R9 rise-only spike no irq", irq, 0);
    chk("R10 single edge stays first", first, 1);
    rise_after(15);
    chk("R8 rise-only valid", cap(), 17);
    chk("R8 rise-only irq", irq, 1);

    start_run(0, 0, 1, 0, 1, 1, 10);
    pin = 1'b0;
    repeat (4) @(negedge clk);
    start_run(0, 0, 1, 0, 1, 1, 10);
    pulse_after(5);
    repeat (260) @(negedge clk);
    chk("R3 overflow while waiting", overflow, 1);
    pulse_after(40);
    chk("R9 overflowed capture", cap(), 46);
    chk("R9 overflow no irq", irq, 0);
    chk("R9 overflow cleared", overflow, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule